// File: doc/BRIEF.md
# Flash Page Load Buffer

This block gathers the data for one flash page-program operation. A command decoder arms it with a single-cycle strobe and fixes the data width for the whole page at that moment. In byte mode each load carries one byte; in word mode each load carries two bytes. After arming, write loads may come in any order. Each one lands in a 128-byte staging buffer, and a per-byte flag records that the location was loaded. The first accepted load fixes the page number, which is the address bits above the in-page offset. Later loads that name any other page are dropped and raise a sticky error.

A quiet-time counter closes the load window. It restarts on every accepted load. When it reaches its limit with no new load, the block leaves the collecting state and pulses a start strobe to the array writer. At that point it presents the page number, the width and the full 128-byte image. Locations that were never loaded read as the erased value FFh. A second, shorter limit flags loads that arrived later than the recommended spacing without closing the window. The image stays on the output until the next arm.

Top module: `page_load_buffer`

## Requirements
- R1: After reset the block is idle (`busy_o`=0). `pg_start_o`, `addr_err_o` and `late_o` are 0, and every byte of `pg_data_o` reads FFh.
- R2: An `arm_i` strobe makes `busy_o` 1 on the next cycle and clears `addr_err_o` and `late_o`. It discards all previously loaded bytes, so `pg_data_o` reads all FFh. It also latches `wide_i` onto `pg_wide_o`.
- R3: In byte mode (`wide_i`=0 at arm), a load writes `ld_data_i[7:0]` to byte `ld_addr_i[6:0]` of the page image. Image byte i is `pg_data_o[8*i+7:8*i]`.
- R4: In word mode, a load writes word `ld_addr_i[6:1]`. `ld_data_i[7:0]` goes to even byte 2w and `ld_data_i[15:8]` goes to odd byte 2w+1. `ld_addr_i[0]` is ignored.
- R5: Loads may target locations in any order. A later load to an already loaded location replaces the earlier data.
- R6: Every byte not loaded since the last arm reads FFh in `pg_data_o`.
- R7: `pg_addr_o` carries `ld_addr_i[ADDR_W-1:7]` of the first load accepted after the arm.
- R8: While collecting, a load whose page bits differ from the latched page is ignored and sets `addr_err_o`. It changes no image byte and does not restart the quiet-time counter. `addr_err_o` stays set until the next arm.
- R9: `pg_start_o` is a single-cycle pulse. It rises exactly GAP_CYC cycles after the clock edge of the last accepted load, provided no load was accepted in between. `busy_o` falls on the same edge.
- R10: An accepted load that comes more than LATE_CYC cycles after the previous accepted load of the same page sets `late_o`. The load is still taken. `late_o` stays set until the next arm.
- R11: Loads while idle are ignored: the image, `busy_o` and `pg_start_o` do not change. An armed block that receives no load waits without timing out.
- R12: When `arm_i` and `ld_valid_i` are high in the same cycle, the arm wins and that load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start a new page collection |
| wide_i | input | 1 | Width at arm: 1 = word loads, 0 = byte loads |
| ld_valid_i | input | 1 | Load write strobe |
| ld_addr_i | input | ADDR_W | Byte address of the load |
| ld_data_i | input | 16 | Load data (low byte only in byte mode) |
| busy_o | output | 1 | Armed and waiting for or collecting loads |
| pg_start_o | output | 1 | One-cycle program start strobe |
| pg_addr_o | output | ADDR_W-7 | Latched page number |
| pg_wide_o | output | 1 | Width latched at arm |
| pg_data_o | output | 1024 | Page image, byte i at bits 8i+7..8i |
| addr_err_o | output | 1 | Sticky: load to a foreign page was dropped |
| late_o | output | 1 | Sticky: a load exceeded the spacing limit |

## Verification
The bench measures the start pulse to the exact cycle. It puts a foreign-page load in the quiet window, so a design that let that load restart the counter would fire late and be caught. Loads spaced exactly GAP_CYC-1 idle cycles apart must be accepted without closing the window, and a spacing of exactly LATE_CYC idle cycles must set the late flag. An off-by-one in either compare shows up as an early start or a missing flag. Word loads with the low address bit set, overwrites, an arm that collides with a load, and a re-arm after a finished page cover lane steering and clearing. A design that kept stale bytes or honoured the colliding load would show non-FFh bytes or the wrong page number.

// File: rtl/pgld_pkg.sv
package pgld_pkg;
   typedef enum logic [1:0] {
      PL_IDLE    = 2'd0,
      PL_WAIT    = 2'd1,
      PL_COLLECT = 2'd2
   } pl_state_e;

   localparam logic [7:0] PL_ERASED = 8'hFF;
   localparam int         PL_WORD_W = 16;
endpackage

// File: rtl/pgld_timer.sv
module pgld_timer #(
   parameter int GAP_CYC  = 25000,
   parameter int LATE_CYC = 7500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic kick_i,
   output logic expire_o,
   output logic late_o
);
   localparam int CW = $clog2(GAP_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run_i || kick_i) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i && !kick_i && (cnt_q == CW'(GAP_CYC - 1));

   generate
      if (LATE_CYC > 0) begin : g_late
         assign late_o = run_i && kick_i && (cnt_q >= CW'(LATE_CYC));
      end else begin : g_nolate
         assign late_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pgld_store.sv
module pgld_store
   import pgld_pkg::*;
#(
   parameter int PAGE_BYTES = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      wr_i,
   input  logic                      wide_i,
   input  logic [$clog2(PAGE_BYTES)-1:0] idx_i,
   input  logic [PL_WORD_W-1:0]      data_i,
   output logic [PAGE_BYTES*8-1:0]   page_o
);
   localparam int IDX_W = $clog2(PAGE_BYTES);

   generate
      for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
         localparam logic [IDX_W-1:0] BI = IDX_W'(b);
         logic       hit;
         logic [7:0] lane;
         logic [7:0] mem_q;
         logic       flag_q;

         assign hit = wr_i && (wide_i ? (idx_i[IDX_W-1:1] == BI[IDX_W-1:1])
                                      : (idx_i == BI));
         if (b % 2 == 1) begin : g_odd
            assign lane = wide_i ? data_i[15:8] : data_i[7:0];
         end else begin : g_even
            assign lane = data_i[7:0];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
               mem_q  <= PL_ERASED;
            end else if (clr_i) begin
               flag_q <= 1'b0;
            end else if (hit) begin
               flag_q <= 1'b1;
               mem_q  <= lane;
            end
         end

         assign page_o[b*8 +: 8] = flag_q ? mem_q : PL_ERASED;
      end
   endgenerate
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
   import pgld_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int PAGE_BYTES = 128,
   parameter int GAP_CYC    = 25000,
   parameter int LATE_CYC   = 7500
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 arm_i,
   input  logic                                 wide_i,
   input  logic                                 ld_valid_i,
   input  logic [ADDR_W-1:0]                    ld_addr_i,
   input  logic [15:0]                          ld_data_i,
   output logic                                 busy_o,
   output logic                                 pg_start_o,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pg_addr_o,
   output logic                                 pg_wide_o,
   output logic [PAGE_BYTES*8-1:0]              pg_data_o,
   output logic                                 addr_err_o,
   output logic                                 late_o
);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFS_W;

   if (PAGE_BYTES < 4 || (1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 4");
   end
   if (PG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the in-page offset width");
   end
   if (GAP_CYC < 2 || LATE_CYC >= GAP_CYC) begin : g_bad_time
      $error("need GAP_CYC >= 2 and LATE_CYC < GAP_CYC");
   end

   pl_state_e       st_q;
   logic [PG_W-1:0] page_q;
   logic [PG_W-1:0] ld_pg;
   logic            wide_q, err_q, late_q, start_q;
   logic            page_hit, accept, stray, run, expire, late_hit;

   assign ld_pg    = ld_addr_i[ADDR_W-1:OFS_W];
   assign page_hit = (ld_pg == page_q);
   assign accept   = ld_valid_i && !arm_i &&
                     ((st_q == PL_WAIT) || ((st_q == PL_COLLECT) && page_hit));
   assign stray    = ld_valid_i && !arm_i && (st_q == PL_COLLECT) && !page_hit;
   assign run      = (st_q == PL_COLLECT) && !arm_i;

   pgld_timer #(
      .GAP_CYC  (GAP_CYC),
      .LATE_CYC (LATE_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .kick_i   (accept),
      .expire_o (expire),
      .late_o   (late_hit)
   );

   pgld_store #(
      .PAGE_BYTES (PAGE_BYTES)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (arm_i),
      .wr_i   (accept),
      .wide_i (wide_q),
      .idx_i  (ld_addr_i[OFS_W-1:0]),
      .data_i (ld_data_i),
      .page_o (pg_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PL_IDLE;
         page_q  <= '0;
         wide_q  <= 1'b0;
         err_q   <= 1'b0;
         late_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (arm_i) begin
            st_q   <= PL_WAIT;
            wide_q <= wide_i;
            err_q  <= 1'b0;
            late_q <= 1'b0;
         end else begin
            unique case (st_q)
               PL_WAIT: begin
                  if (accept) begin
                     page_q <= ld_pg;
                     st_q   <= PL_COLLECT;
                  end
               end
               PL_COLLECT: begin
                  if (stray)    err_q  <= 1'b1;
                  if (late_hit) late_q <= 1'b1;
                  if (expire) begin
                     st_q    <= PL_IDLE;
                     start_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign busy_o     = (st_q != PL_IDLE);
   assign pg_start_o = start_q;
   assign pg_addr_o  = page_q;
   assign pg_wide_o  = wide_q;
   assign addr_err_o = err_q;
   assign late_o     = late_q;
endmodule

// File: rtl/pgld_chk.sv
module pgld_chk #(
   parameter int PAGE_BYTES = 128
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    arm_i,
   input logic                    wide_i,
   input logic                    busy_o,
   input logic                    pg_start_o,
   input logic                    pg_wide_o,
   input logic [PAGE_BYTES*8-1:0] pg_data_o,
   input logic                    addr_err_o,
   input logic                    late_o
);
   // R2
   arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (busy_o && !addr_err_o && !late_o));

   // R2
   arm_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (pg_wide_o == $past(wide_i)));

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_start_o |=> !pg_start_o);

   // R9
   start_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_start_o |-> (!busy_o && $past(busy_o)));

   // R11
   idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> !pg_start_o);

   // R11
   idle_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !arm_i) |=> $stable(pg_data_o));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err_o && !arm_i) |=> addr_err_o);

   // R10
   late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (late_o && !arm_i) |=> late_o);
endmodule

bind page_load_buffer pgld_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm_i      (arm_i),
   .wide_i     (wide_i),
   .busy_o     (busy_o),
   .pg_start_o (pg_start_o),
   .pg_wide_o  (pg_wide_o),
   .pg_data_o  (pg_data_o),
   .addr_err_o (addr_err_o),
   .late_o     (late_o)
);

// File: tb/page_load_buffer_test.sv
`timescale 1ns/1ps
module page_load_buffer_test;
   localparam int AW   = 20;
   localparam int PB   = 128;
   localparam int GAP  = 40;
   localparam int LATE = 12;
   localparam int PW   = AW - 7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           arm_i = 1'b0, wide_i = 1'b0, ld_valid_i = 1'b0;
   logic [AW-1:0]  ld_addr_i = '0;
   logic [15:0]    ld_data_i = '0;
   logic           busy_o, pg_start_o, pg_wide_o, addr_err_o, late_o;
   logic [PW-1:0]  pg_addr_o;
   logic [PB*8-1:0] pg_data_o;

   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;
   logic [7:0] m_mem [PB];
   bit   m_flag [PB];
   bit   m_wide, m_err, m_late, m_first;
   logic [PW-1:0] m_page;

   always #2 clk = ~clk;

   page_load_buffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .GAP_CYC(GAP), .LATE_CYC(LATE)) uut (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .wide_i(wide_i),
      .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
      .busy_o(busy_o), .pg_start_o(pg_start_o), .pg_addr_o(pg_addr_o),
      .pg_wide_o(pg_wide_o), .pg_data_o(pg_data_o),
      .addr_err_o(addr_err_o), .late_o(late_o));

   function automatic logic [7:0] exp_byte(int i);
      return m_flag[i] ? m_mem[i] : 8'hFF;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_page(input string req);
      int bad = -1;
      for (int i = 0; i < PB; i++)
         if (bad < 0 && pg_data_o[i*8 +: 8] !== exp_byte(i)) bad = i;
      if (bad < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, {req, " image byte"}, {bad[15:0], 8'h00, pg_data_o[bad*8 +: 8]},
               {bad[15:0], 8'h00, exp_byte(bad)});
   endtask

   task automatic model_clear();
      for (int i = 0; i < PB; i++) m_flag[i] = 1'b0;
      m_err = 0; m_late = 0; m_first = 1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic arm(input bit w, input bit with_load, input logic [AW-1:0] a);
      arm_i = 1'b1; wide_i = w;
      ld_valid_i = with_load; ld_addr_i = a; ld_data_i = 16'h5A5A;
      @(negedge clk);
      arm_i = 1'b0; ld_valid_i = 1'b0;
      model_clear(); m_wide = w;
   endtask

   task automatic send(input logic [AW-1:0] a, input logic [15:0] d, input int gap);
      int o = a[6:0];
      ld_valid_i = 1'b1; ld_addr_i = a; ld_data_i = d;
      if (m_first) m_page = a[AW-1:7];
      else if (gap >= LATE) m_late = 1;
      m_first = 0;
      if (m_wide) begin
         o = o & ~1;
         m_mem[o] = d[7:0];  m_flag[o] = 1;
         m_mem[o+1] = d[15:8]; m_flag[o+1] = 1;
      end else begin
         m_mem[o] = d[7:0]; m_flag[o] = 1;
      end
      @(negedge clk);
      ld_valid_i = 1'b0;
   endtask

   // called right after the last accepted load; bad_at > 0 injects a foreign-page load
   task automatic finish_page(input int bad_at, input string tag);
      bit sok = 1'b1;
      for (int c = 1; c <= GAP + 1; c++) begin
         if (pg_start_o !== (c == GAP + 1)) sok = 1'b0;
         ld_valid_i = 1'b0;
         if (c == bad_at) begin
            ld_valid_i = 1'b1;
            ld_addr_i  = {m_page ^ PW'(1), 7'h11};
            ld_data_i  = 16'h0000;
            m_err = 1;
         end
         if (c <= GAP) @(negedge clk);
      end
      chk(sok, {"R9 start timing ", tag}, pg_start_o, 1);
      chk(busy_o === 1'b0, {"R9 busy drops ", tag}, busy_o, 0);
      check_page({"R3 R4 R5 R6 image ", tag});
      chk(pg_addr_o === m_page, {"R7 page address ", tag}, pg_addr_o, m_page);
      chk(addr_err_o === m_err, {"R8 error flag ", tag}, addr_err_o, m_err);
      chk(late_o === m_late, {"R10 late flag ", tag}, late_o, m_late);
      chk(pg_wide_o === m_wide, {"R2 width ", tag}, pg_wide_o, m_wide);
      @(negedge clk);
      chk(pg_start_o === 1'b0, {"R9 single pulse ", tag}, pg_start_o, 0);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      model_clear(); m_wide = 0; m_page = '0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1
      chk(busy_o === 0 && pg_start_o === 0 && addr_err_o === 0 && late_o === 0,
          "R1 reset flags", {busy_o, pg_start_o, addr_err_o, late_o}, 0);
      check_page("R1 reset image");

      // R11: load while idle
      ld_valid_i = 1; ld_addr_i = 20'h00005; ld_data_i = 16'h0012;
      @(negedge clk); ld_valid_i = 0;
      idle(2);
      check_page("R11 idle load image");
      chk(busy_o === 0 && pg_start_o === 0, "R11 idle load busy", busy_o, 0);

      // R2 arm byte mode, R11 wait forever
      arm(1'b0, 1'b0, '0);
      chk(busy_o === 1 && pg_wide_o === 0, "R2 arm byte", {busy_o, pg_wide_o}, 2'b10);
      idle(GAP * 3);
      chk(busy_o === 1 && pg_start_o === 0, "R11 armed no timeout", busy_o, 1);

      // directed byte page: out of order, overwrite, late gap, foreign load
      send({13'h0123, 7'd5},   16'hFF11, 0);
      idle(3);  send({13'h0123, 7'd3},   16'h0022, 3);
      idle(0);  send({13'h0123, 7'd127}, 16'h0033, 0);
      idle(LATE - 1); send({13'h0123, 7'd0}, 16'h0044, LATE - 1);
      chk(late_o === 0, "R10 gap at limit not late", late_o, 0);
      idle(GAP - 1); send({13'h0123, 7'd3}, 16'h0055, GAP - 1);
      chk(late_o === 1, "R10 gap above limit late", late_o, 1);
      finish_page(5, "byte");

      // R2 re-arm clears image; R12 arm beats a same-cycle load
      arm(1'b1, 1'b1, {13'h0777, 7'd8});
      check_page("R2 re-arm image");
      chk(addr_err_o === 0 && late_o === 0 && pg_wide_o === 1, "R2 re-arm flags",
          {addr_err_o, late_o, pg_wide_o}, 3'b001);
      idle(2);
      send({13'h0042, 7'd9},  16'hBEEF, 2);
      idle(1); send({13'h0042, 7'd126}, 16'hC0DE, 1);
      idle(4); send({13'h0042, 7'd8},  16'h1234, 4);
      finish_page(0, "word R4 R12");

      // random pages
      for (int p = 0; p < 8; p++) begin
         logic [PW-1:0] pg;
         int n, bad;
         pg = PW'($urandom);
         arm(1'($urandom), 1'b0, '0);
         n = 1 + $urandom % 20;
         for (int k = 0; k < n; k++) begin
            int g;
            if (k == 0) g = $urandom % 5;
            else if ($urandom % 6 == 0) g = LATE + $urandom % (GAP - LATE);
            else g = $urandom % LATE;
            idle(g);
            send({pg, 7'($urandom)}, 16'($urandom), g);
         end
         bad = ($urandom % 3 == 0) ? 1 + $urandom % (GAP - 2) : 0;
         finish_page(bad, $sformatf("random %0d", p));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule